// File: doc/BRIEF.md
# Write-Burst Interrupt Rule Checker

This block watches the decoded command stream of a double-data-rate SDRAM controller. It reports any command that breaks the rules for cutting a write burst short, and any precharge that comes too early after a write. Each clock it takes one decoded command and its bank. It also takes the mode settings (burst length, write latency, write recovery), which it samples whenever a mode-register-set command appears. Until the first such command after reset it flags nothing.

A write may be cut short only by another write, only when the burst length is eight, and only when the second write comes exactly two clocks after the first. The second write may go to any bank. A write with auto-precharge may never be cut short. Precharge spacing is counted from the burst length in the mode settings, not from the beats that actually moved. An interrupted write therefore still holds its bank closed for the full nominal time. The checker raises a one-cycle flag with a code. It also exposes a per-bank count of the cycles left before a precharge to that bank becomes legal.

Top module: `wrint_chk`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `viol` is 0, `viol_code` is 0 and every `pre_wait` field is 0.
- R2: Before the first mode-register-set command (cmd=5) after reset, no command raises `viol` and every `pre_wait` field stays 0.
- R3: With burst length eight (`mr_bl8`=1), a write (cmd=1 or 2) issued exactly two cycles after a plain write (cmd=1) raises no violation, whichever bank it targets.
- R4: With burst length four (`mr_bl8`=0), a write inside the active span of an earlier write is reported with code 1.
- R5: The active span of a write covers offsets 1 to WL+BL/2-1 cycles after it. Inside that span, any command other than NOP (cmd=0) and the two write codes is reported with code 2. This applies to READ=3, PRECHARGE=4, mode set=5, and the codes 6 and 7. Code 2 takes priority over code 5.
- R6: With burst length eight, a write inside the span of a plain write at an offset other than 2 is reported with code 3.
- R7: With burst length eight, a write two cycles after a write with auto-precharge (cmd=2) is reported with code 4.
- R8: In the cycle after any write to bank b, field b of `pre_wait` (bits b*CW+CW-1 down to b*CW) equals WL+BL/2+tWR-1. It then drops by one per cycle and holds at 0.
- R9: A PRECHARGE to bank b outside any write span is reported with code 5 when field b of `pre_wait` is nonzero. It raises nothing when that field is 0.
- R10: When a write is interrupted by a write to another bank, the first bank's `pre_wait` field keeps counting from its own write command, at its full nominal length.
- R11: The verdict for a command appears in the cycle after it, for that cycle only. `viol` is 1 exactly when `viol_code` is nonzero, and a NOP never raises it.
- R12: A command at offset WL+BL/2 or later after the most recent write is outside the span and raises no interrupt violation. Every write, flagged or not, becomes the most recent write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Decoded command: 0 NOP, 1 write, 2 write with auto-precharge, 3 read, 4 precharge, 5 mode set, 6 and 7 other |
| bank | input | BANK_W | Bank of the command |
| mr_bl8 | input | 1 | Burst length setting: 1 for eight, 0 for four |
| mr_wl | input | WL_W | Write latency in cycles |
| mr_twr | input | TWR_W | Write recovery in cycles |
| viol | output | 1 | One-cycle violation flag |
| viol_code | output | 3 | 1 BL4 interrupt, 2 wrong command, 3 wrong offset, 4 auto-precharge interrupt, 5 early precharge |
| pre_wait | output | 2^BANK_W*CW | Per-bank cycles remaining before a precharge is legal |

## Verification
A wrong age or busy state in the write tracker shows up on `viol_code` in the very next cycle. A legal interrupt at offset 2 would come out as code 3, or a command just past the span would come out as code 2. The bench therefore places commands on both edges of the span and at offsets 1 and 2. A wrongly loaded or reloaded bank counter is visible on `pre_wait` one cycle after the write. The bench reads it directly, and also reads it through an early-precharge code or its absence at the exact offset WL+BL/2+tWR.

// File: rtl/wrint_pkg.sv
package wrint_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_WR  = 3'd1,
    CMD_WRA = 3'd2,
    CMD_RD  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_MRS = 3'd5,
    CMD_ACT = 3'd6,
    CMD_REF = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_BL4    = 3'd1,
    ERR_TYPE   = 3'd2,
    ERR_OFFSET = 3'd3,
    ERR_APRE   = 3'd4,
    ERR_EARLY  = 3'd5
  } err_e;

  // only legal distance between a write and the write that cuts it short
  localparam int INT_GAP  = 2;
  // clock cycles of data for each burst length setting
  localparam int HALF_BL8 = 4;
  localparam int HALF_BL4 = 2;

endpackage

// File: rtl/wrint_mode.sv
module wrint_mode #(
  parameter int WL_W  = 4,
  parameter int TWR_W = 4,
  parameter int AGE_W = WL_W + 1,
  parameter int CW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrs_en,
  input  logic             bl8_in,
  input  logic [WL_W-1:0]  wl_in,
  input  logic [TWR_W-1:0] twr_in,
  output logic             armed,
  output logic             bl8,
  output logic [AGE_W-1:0] span_last,
  output logic [CW-1:0]    pre_gap
);
  import wrint_pkg::*;

  logic             armed_q, armed_d;
  logic             bl8_q, bl8_d;
  logic [WL_W-1:0]  wl_q, wl_d;
  logic [TWR_W-1:0] twr_q, twr_d;
  logic [2:0]       half;

  always_comb begin
    armed_d = armed_q;
    bl8_d   = bl8_q;
    wl_d    = wl_q;
    twr_d   = twr_q;
    if (mrs_en) begin
      armed_d = 1'b1;
      bl8_d   = bl8_in;
      wl_d    = wl_in;
      twr_d   = twr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      bl8_q   <= 1'b0;
      wl_q    <= '0;
      twr_q   <= '0;
    end else if (mrs_en) begin
      armed_q <= armed_d;
      bl8_q   <= bl8_d;
      wl_q    <= wl_d;
      twr_q   <= twr_d;
    end
  end

  always_comb begin
    half      = bl8_q ? 3'(HALF_BL8) : 3'(HALF_BL4);
    span_last = AGE_W'(wl_q) + AGE_W'(half) - AGE_W'(1);
    pre_gap   = CW'(wl_q) + CW'(half) + CW'(twr_q);
  end

  assign armed = armed_q;
  assign bl8   = bl8_q;

endmodule

// File: rtl/wrint_burst.sv
module wrint_burst #(
  parameter int AGE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  wrint_pkg::cmd_e  cmd,
  input  logic             bl8,
  input  logic [AGE_W-1:0] span_last,
  output wrint_pkg::err_e  err
);
  import wrint_pkg::*;

  logic             busy_q, busy_d;
  logic             apre_q, apre_d;
  logic [AGE_W-1:0] age_q, age_d;
  logic             st_en;
  logic             is_wr;
  logic             in_span;

  // judgement of the current command against the most recent write
  always_comb begin
    is_wr   = (cmd == CMD_WR) || (cmd == CMD_WRA);
    in_span = busy_q && (age_q <= span_last);
    err     = ERR_NONE;
    if (en && in_span && (cmd != CMD_NOP)) begin
      if (!is_wr)                         err = ERR_TYPE;
      else if (!bl8)                      err = ERR_BL4;
      else if (apre_q)                    err = ERR_APRE;
      else if (age_q != AGE_W'(INT_GAP))  err = ERR_OFFSET;
    end
  end

  // tracker next state: any write restarts the age at one
  always_comb begin
    st_en  = (en && is_wr) || busy_q;
    busy_d = busy_q;
    apre_d = apre_q;
    age_d  = age_q;
    if (en && is_wr) begin
      busy_d = 1'b1;
      apre_d = (cmd == CMD_WRA);
      age_d  = AGE_W'(1);
    end else if (age_q >= span_last) begin
      busy_d = 1'b0;
    end else begin
      age_d  = age_q + AGE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      apre_q <= 1'b0;
      age_q  <= '0;
    end else if (st_en) begin
      busy_q <= busy_d;
      apre_q <= apre_d;
      age_q  <= age_d;
    end
  end

endmodule

// File: rtl/wrint_prectr.sv
module wrint_prectr #(
  parameter int BANK_W = 3,
  parameter int CW     = 6,
  parameter int NBANK  = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  wrint_pkg::cmd_e   cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [CW-1:0]     pre_gap,
  output logic              early,
  output logic [NBANK*CW-1:0] cnt_flat
);
  import wrint_pkg::*;

  logic [CW-1:0] cnt_q [NBANK];
  logic          is_wr;

  assign is_wr = (cmd == CMD_WR) || (cmd == CMD_WRA);
  assign early = en && (cmd == CMD_PRE) && (cnt_q[bank] != '0);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic          ld;
    logic          ce;
    logic [CW-1:0] cnt_d;

    always_comb begin
      ld    = en && is_wr && (bank == BANK_W'(b));
      ce    = ld || (cnt_q[b] != '0);
      cnt_d = ld ? (pre_gap - CW'(1)) : (cnt_q[b] - CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt_q[b] <= '0;
      else if (ce) cnt_q[b] <= cnt_d;
    end

    assign cnt_flat[b*CW +: CW] = cnt_q[b];
  end

endmodule

// File: rtl/wrint_chk.sv
module wrint_chk #(
  parameter int BANK_W = 3,
  parameter int WL_W   = 4,
  parameter int TWR_W  = 4,
  parameter int CW     = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 cmd,
  input  logic [BANK_W-1:0]          bank,
  input  logic                       mr_bl8,
  input  logic [WL_W-1:0]            mr_wl,
  input  logic [TWR_W-1:0]           mr_twr,
  output logic                       viol,
  output logic [2:0]                 viol_code,
  output logic [(1<<BANK_W)*CW-1:0]  pre_wait
);
  import wrint_pkg::*;

  localparam int NBANK = 1 << BANK_W;
  localparam int AGE_W = WL_W + 1;

  cmd_e             cmd_t;
  logic             armed;
  logic             bl8;
  logic [AGE_W-1:0] span_last;
  logic [CW-1:0]    pre_gap;
  err_e             burst_err;
  logic             early;
  err_e             code_d;
  logic             viol_q;
  err_e             code_q;

  assign cmd_t = cmd_e'(cmd);

  wrint_mode #(.WL_W(WL_W), .TWR_W(TWR_W), .AGE_W(AGE_W), .CW(CW)) u_mode (
    .clk(clk), .rst_n(rst_n), .mrs_en(cmd_t == CMD_MRS),
    .bl8_in(mr_bl8), .wl_in(mr_wl), .twr_in(mr_twr),
    .armed(armed), .bl8(bl8), .span_last(span_last), .pre_gap(pre_gap)
  );

  wrint_burst #(.AGE_W(AGE_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .en(armed), .cmd(cmd_t),
    .bl8(bl8), .span_last(span_last), .err(burst_err)
  );

  wrint_prectr #(.BANK_W(BANK_W), .CW(CW), .NBANK(NBANK)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(armed), .cmd(cmd_t), .bank(bank),
    .pre_gap(pre_gap), .early(early), .cnt_flat(pre_wait)
  );

  // burst rule verdicts outrank the spacing verdict
  always_comb begin
    code_d = ERR_NONE;
    if (burst_err != ERR_NONE) code_d = burst_err;
    else if (early)            code_d = ERR_EARLY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
      code_q <= ERR_NONE;
    end else begin
      viol_q <= (code_d != ERR_NONE);
      code_q <= code_d;
    end
  end

  assign viol      = viol_q;
  assign viol_code = code_q;

endmodule

// File: rtl/wrint_chk_sva.sv
module wrint_chk_sva #(
  parameter int BANK_W = 3,
  parameter int CW     = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [2:0]                cmd,
  input logic [BANK_W-1:0]         bank,
  input logic                      viol,
  input logic [2:0]                viol_code,
  input logic [(1<<BANK_W)*CW-1:0] pre_wait
);
  localparam int NBANK = 1 << BANK_W;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          seen_q;
  logic [CW-1:0] cnt_a [NBANK];
  logic          wr_now;

  assign wr_now = (cmd == 3'd1) || (cmd == 3'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              seen_q <= 1'b0;
    else if (cmd == 3'd5)    seen_q <= 1'b1;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_b
    assign cnt_a[b] = pre_wait[b*CW +: CW];

    // R8: each bank field counts down by one when not reloaded
    a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_a[b] != '0 && !(wr_now && seen_q && bank == BANK_W'(b)))
      |=> ($past(cnt_a[b]) == cnt_a[b] + ONE));

    a_r8_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_a[b] == '0 && !(wr_now && seen_q && bank == BANK_W'(b)))
      |=> (cnt_a[b] == '0));
  end

  a_r11_flag_has_code: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (viol_code != 3'd0));

  a_r1_quiet_code: assert property (@(posedge clk) disable iff (!rst_n)
    !viol |-> (viol_code == 3'd0));

  a_r11_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd0) |=> !viol);

  a_r2_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_q && cmd != 3'd5) |=> !viol);

  a_r2_unarmed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (pre_wait == '0));

  a_r9_early_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && cmd == 3'd4 && cnt_a[bank] != '0) |=> viol);

endmodule

bind wrint_chk wrint_chk_sva #(.BANK_W(BANK_W), .CW(CW)) u_sva (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank),
  .viol(viol), .viol_code(viol_code), .pre_wait(pre_wait)
);

// File: tb/wrint_chk_test.sv
module wrint_chk_test;
  localparam int CLK_P = 10;
  localparam int CWT   = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cmd;
  logic [2:0] bank;
  logic       mr_bl8;
  logic [3:0] mr_wl;
  logic [3:0] mr_twr;
  logic       viol;
  logic [2:0] viol_code;
  logic [8*CWT-1:0] pre_wait;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic [2:0] code;
    string      tag;
  } exp_t;
  exp_t q[$];

  wrint_chk uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank),
    .mr_bl8(mr_bl8), .mr_wl(mr_wl), .mr_twr(mr_twr),
    .viol(viol), .viol_code(viol_code), .pre_wait(pre_wait)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] c, logic [2:0] b, logic [2:0] code, string tag);
    exp_t it;
    @(negedge clk);
    cmd  = c;
    bank = b;
    it.code = code;
    it.tag  = tag;
    q.push_back(it);
  endtask

  task automatic nops(int n);
    for (int i = 0; i < n; i++) issue(3'd0, 3'd0, 3'd0, "R11 nop");
  endtask

  function automatic int cnt_of(int b);
    return int'(pre_wait[b*CWT +: CWT]);
  endfunction

  // monitor: verdict for the command driven before an edge is visible just after it
  initial forever begin
    @(posedge clk);
    #1;
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " code"}, int'(viol_code), int'(e.code));
      chk({e.tag, " flag"}, int'(viol), int'(e.code != 3'd0));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    cmd    = 3'd0;
    bank   = 3'd0;
    mr_bl8 = 1'b1;
    mr_wl  = 4'd3;
    mr_twr = 4'd3;
    repeat (2) @(negedge clk);
    chk("R1 reset viol", int'(viol), 0);
    chk("R1 reset code", int'(viol_code), 0);
    chk("R1 reset counters", int'(pre_wait != '0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset viol", int'(viol), 0);

    // R2: rules not applied before the first mode set
    issue(3'd1, 3'd0, 3'd0, "R2 unarmed write");
    issue(3'd1, 3'd0, 3'd0, "R2 unarmed offset1 write");
    issue(3'd4, 3'd0, 3'd0, "R2 unarmed precharge");
    nops(1);
    chk("R2 counters idle", int'(pre_wait != '0), 0);

    // arm: BL8, WL=3, tWR=3 -> gap 10, span offsets 1..6
    issue(3'd5, 3'd0, 3'd0, "R2 mode set");
    nops(2);

    // R3 legal interrupt to another bank, R10 nominal spacing kept
    issue(3'd1, 3'd0, 3'd0, "R3 first write");
    issue(3'd0, 3'd0, 3'd0, "R3 gap");
    issue(3'd1, 3'd1, 3'd0, "R3 interrupt other bank");
    issue(3'd0, 3'd0, 3'd0, "R3 after");
    chk("R10 bank0 counter", cnt_of(0), 7);
    chk("R8 bank1 counter", cnt_of(1), 9);
    nops(5);
    issue(3'd4, 3'd0, 3'd5, "R10 precharge bank0 offset9");
    issue(3'd4, 3'd0, 3'd0, "R9 precharge bank0 offset10");
    issue(3'd4, 3'd1, 3'd5, "R9 precharge bank1 offset9");
    issue(3'd4, 3'd1, 3'd0, "R9 precharge bank1 offset10");
    nops(10);

    // R6 wrong offset, R5 wrong type, R12 span edge
    issue(3'd1, 3'd2, 3'd0, "R6 first write");
    issue(3'd1, 3'd2, 3'd3, "R6 write offset1");
    issue(3'd0, 3'd0, 3'd0, "R6 gap");
    issue(3'd3, 3'd2, 3'd2, "R5 read in span");
    nops(3);
    issue(3'd4, 3'd2, 3'd2, "R5 precharge at last span cycle");
    issue(3'd1, 3'd2, 3'd0, "R12 write past span");
    nops(10);

    // R7 interrupt of an auto-precharge write
    issue(3'd2, 3'd3, 3'd0, "R7 auto-precharge write");
    issue(3'd0, 3'd0, 3'd0, "R7 gap");
    issue(3'd1, 3'd3, 3'd4, "R7 interrupt");
    nops(10);

    // R4 burst length four: gap 8, span offsets 1..4
    mr_bl8 = 1'b0;
    issue(3'd5, 3'd0, 3'd0, "R4 mode set bl4");
    nops(2);
    issue(3'd1, 3'd0, 3'd0, "R4 first write");
    issue(3'd0, 3'd0, 3'd0, "R4 gap");
    issue(3'd1, 3'd1, 3'd1, "R4 interrupt");
    issue(3'd0, 3'd0, 3'd0, "R11 clear after flag");
    chk("R8 bl4 bank0 counter", cnt_of(0), 5);
    chk("R8 bl4 bank1 counter", cnt_of(1), 7);
    nops(12);
    chk("R8 counter saturates", cnt_of(1), 0);

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule